// File: doc/BRIEF.md
# Banked Shadow Register File

This block is a general-purpose register file that holds several complete copies of the 32-entry register set. A fast interrupt handler does not spill and refill registers in software. When an interrupt is taken, the handler moves to a clean copy, and when it returns, the interrupted copy comes back. Each cycle the file serves two source reads and one destination write, which matches a three-operand instruction format. Register 0 of every copy is fixed at zero.

A small state machine holds the active copy number and the number of the copy that was active before the last interrupt. An interrupt entry records the active copy as the saved copy and activates the requested one. A return activates the saved copy again. Software can also load the active copy directly. Either read port can be pointed at the saved copy, so a handler can inspect or fetch the interrupted code's operands. Read data is registered and appears one cycle after the address. A write in the same cycle to the register being read is forwarded to the read port.

Top module: `shadow_regfile`

## Requirements
- R1: After synchronous active-high reset, `cur_set` and `saved_set` are both 0 and both read data outputs are 0.
- R2: A read of register 0 in any copy returns 0 on the next cycle, including after a write to register 0.
- R3: Each read port returns the word at its address on the cycle after the address is presented, from the active copy when its `*_prev` bit is 0.
- R4: A write lands in the active copy only, and the same register number in every other copy keeps its value.
- R5: When a read of the active copy and a write to the same nonzero register happen in the same cycle, the read returns the new data. A read of a different copy is not forwarded.
- R6: When `irq_enter` is 1, the next cycle shows `saved_set` equal to the old `cur_set` and `cur_set` equal to the requested `irq_set`.
- R7: When `irq_return` is 1 and `irq_enter` is 0, the next cycle shows `cur_set` equal to `saved_set`, and `saved_set` is unchanged.
- R8: A requested copy number (from `irq_set` or `set_sel`) that is equal to or above `NUM_SETS` selects copy 0, so `cur_set` never reaches `NUM_SETS`.
- R9: A read port with its `*_prev` bit at 1 reads the copy named by `saved_set`.
- R10: `set_sel_en` loads `cur_set` and leaves `saved_set` unchanged. When several set controls are high together, `irq_enter` wins over `irq_return`, and `irq_return` wins over `set_sel_en`. When none is high, `cur_set` holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_sel_en | input | 1 | Load active copy from `set_sel` |
| set_sel | input | 3 | Copy number for a direct load |
| irq_enter | input | 1 | Interrupt entry: save active copy, switch to `irq_set` |
| irq_set | input | 3 | Copy requested by the interrupt |
| irq_return | input | 1 | Interrupt return: reactivate saved copy |
| rd_a_addr | input | 5 | Read port A register number |
| rd_a_prev | input | 1 | Port A reads the saved copy |
| rd_b_addr | input | 5 | Read port B register number |
| rd_b_prev | input | 1 | Port B reads the saved copy |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Destination register number |
| wr_data | input | 32 | Write data |
| rd_a_data | output | 32 | Port A data, one cycle after address |
| rd_b_data | output | 32 | Port B data, one cycle after address |
| cur_set | output | 3 | Active copy number |
| saved_set | output | 3 | Copy active before the last interrupt entry |

## Verification
Reads are tested on their own, alongside a write to the same register, and alongside a write to the same register number while the port points at the saved copy. This separates correct forwarding from forwarding that ignores the copy number. Each copy is filled with different values for the same register numbers, so a read from the wrong copy shows up as a data mismatch. The set controls are driven one at a time and in conflicting pairs, with requested numbers both in range and above `NUM_SETS`. These patterns show whether the priority order and the clamping are right.

// File: rtl/srf_pkg.sv
package srf_pkg;
  localparam int SET_W    = 3;
  localparam int MAX_SETS = 1 << SET_W;

  // Out-of-range request selects copy 0.
  function automatic logic [SET_W-1:0] clamp_set(input logic [SET_W-1:0] req,
                                                 input int unsigned n_sets);
    return (int'(req) >= int'(n_sets)) ? '0 : req;
  endfunction
endpackage

// File: rtl/srf_set_ctrl.sv
module srf_set_ctrl
  import srf_pkg::*;
#(
  parameter int NUM_SETS = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enter,
  input  logic [SET_W-1:0] enter_set,
  input  logic             leave,
  input  logic             load,
  input  logic [SET_W-1:0] load_set,
  output logic [SET_W-1:0] active,
  output logic [SET_W-1:0] stashed
);
  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= '0;
      stashed <= '0;
    end else if (enter) begin
      stashed <= active;
      active  <= clamp_set(enter_set, NUM_SETS);
    end else if (leave) begin
      active  <= stashed;
    end else if (load) begin
      active  <= clamp_set(load_set, NUM_SETS);
    end
  end
endmodule

// File: rtl/srf_bank_mem.sv
module srf_bank_mem
  import srf_pkg::*;
#(
  parameter int NUM_SETS = 4,
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 32,
  parameter int N_RD     = 2,
  localparam int ADDR_W  = $clog2(NUM_REGS),
  localparam int DEPTH   = NUM_SETS * NUM_REGS,
  localparam int IDX_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              we,
  input  logic [SET_W-1:0]  w_set,
  input  logic [ADDR_W-1:0] w_addr,
  input  logic [DATA_W-1:0] w_data,
  input  logic [SET_W-1:0]  r_set  [N_RD],
  input  logic [ADDR_W-1:0] r_addr [N_RD],
  output logic [DATA_W-1:0] r_q    [N_RD]
);
  logic [DATA_W-1:0] mem [DEPTH];

  function automatic logic [IDX_W-1:0] flat(input logic [SET_W-1:0] s,
                                            input logic [ADDR_W-1:0] a);
    return IDX_W'(int'(s) * NUM_REGS + int'(a));
  endfunction

  always_ff @(posedge clk) begin
    if (we && (w_addr != '0)) mem[flat(w_set, w_addr)] <= w_data;
  end

  for (genvar p = 0; p < N_RD; p++) begin : g_rd
    always_ff @(posedge clk) r_q[p] <= mem[flat(r_set[p], r_addr[p])];
  end
endmodule

// File: rtl/srf_read_port.sv
module srf_read_port
  import srf_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 32,
  localparam int ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              use_prev,
  input  logic [SET_W-1:0]  active,
  input  logic [SET_W-1:0]  stashed,
  input  logic              we,
  input  logic [ADDR_W-1:0] w_addr,
  input  logic [DATA_W-1:0] w_data,
  input  logic [DATA_W-1:0] mem_q,
  output logic [SET_W-1:0]  sel_set,
  output logic [DATA_W-1:0] data
);
  logic              zero_q, fwd_q;
  logic [DATA_W-1:0] fwd_data_q;
  logic              fwd_hit;

  assign sel_set = use_prev ? stashed : active;
  assign fwd_hit = we && (w_addr == addr) && (addr != '0) && (sel_set == active);

  always_ff @(posedge clk) begin
    if (rst) begin
      zero_q     <= 1'b1;
      fwd_q      <= 1'b0;
      fwd_data_q <= '0;
    end else begin
      zero_q     <= (addr == '0);
      fwd_q      <= fwd_hit;
      fwd_data_q <= w_data;
    end
  end

  always_comb begin
    if (zero_q)     data = '0;
    else if (fwd_q) data = fwd_data_q;
    else            data = mem_q;
  end
endmodule

// File: rtl/shadow_regfile.sv
module shadow_regfile
  import srf_pkg::*;
#(
  parameter int NUM_SETS = 4,
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 32,
  localparam int ADDR_W  = $clog2(NUM_REGS),
  localparam int N_RD    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_sel_en,
  input  logic [SET_W-1:0]  set_sel,
  input  logic              irq_enter,
  input  logic [SET_W-1:0]  irq_set,
  input  logic              irq_return,
  input  logic [ADDR_W-1:0] rd_a_addr,
  input  logic              rd_a_prev,
  input  logic [ADDR_W-1:0] rd_b_addr,
  input  logic              rd_b_prev,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_a_data,
  output logic [DATA_W-1:0] rd_b_data,
  output logic [SET_W-1:0]  cur_set,
  output logic [SET_W-1:0]  saved_set
);
  logic [ADDR_W-1:0] p_addr [N_RD];
  logic              p_prev [N_RD];
  logic [SET_W-1:0]  p_set  [N_RD];
  logic [DATA_W-1:0] p_q    [N_RD];
  logic [DATA_W-1:0] p_data [N_RD];

  assign p_addr[0] = rd_a_addr;
  assign p_addr[1] = rd_b_addr;
  assign p_prev[0] = rd_a_prev;
  assign p_prev[1] = rd_b_prev;
  assign rd_a_data = p_data[0];
  assign rd_b_data = p_data[1];

  srf_set_ctrl #(.NUM_SETS(NUM_SETS)) u_ctrl (
    .clk(clk), .rst(rst),
    .enter(irq_enter), .enter_set(irq_set),
    .leave(irq_return),
    .load(set_sel_en), .load_set(set_sel),
    .active(cur_set), .stashed(saved_set)
  );

  srf_bank_mem #(
    .NUM_SETS(NUM_SETS), .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .N_RD(N_RD)
  ) u_mem (
    .clk(clk), .we(wr_en), .w_set(cur_set), .w_addr(wr_addr), .w_data(wr_data),
    .r_set(p_set), .r_addr(p_addr), .r_q(p_q)
  );

  for (genvar p = 0; p < N_RD; p++) begin : g_port
    srf_read_port #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_rp (
      .clk(clk), .rst(rst),
      .addr(p_addr[p]), .use_prev(p_prev[p]),
      .active(cur_set), .stashed(saved_set),
      .we(wr_en), .w_addr(wr_addr), .w_data(wr_data),
      .mem_q(p_q[p]),
      .sel_set(p_set[p]), .data(p_data[p])
    );
  end
endmodule

// File: rtl/srf_chk.sv
module srf_chk
  import srf_pkg::*;
#(
  parameter int NUM_SETS = 4,
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 32,
  localparam int ADDR_W  = $clog2(NUM_REGS)
) (
  input logic              clk,
  input logic              rst,
  input logic              set_sel_en,
  input logic [SET_W-1:0]  set_sel,
  input logic              irq_enter,
  input logic [SET_W-1:0]  irq_set,
  input logic              irq_return,
  input logic [ADDR_W-1:0] rd_a_addr,
  input logic              rd_a_prev,
  input logic [ADDR_W-1:0] rd_b_addr,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] rd_a_data,
  input logic [DATA_W-1:0] rd_b_data,
  input logic [SET_W-1:0]  cur_set,
  input logic [SET_W-1:0]  saved_set
);
  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  // R2
  zero_a_chk: assert property (@(posedge clk) disable iff (rst)
    armed && ($past(rd_a_addr) == '0) |-> rd_a_data == '0);
  // R2
  zero_b_chk: assert property (@(posedge clk) disable iff (rst)
    armed && ($past(rd_b_addr) == '0) |-> rd_b_data == '0);
  // R5
  fwd_a_chk: assert property (@(posedge clk) disable iff (rst)
    armed && $past(wr_en && (wr_addr == rd_a_addr) && (wr_addr != '0) && !rd_a_prev)
    |-> rd_a_data == $past(wr_data));
  // R6
  enter_chk: assert property (@(posedge clk) disable iff (rst)
    armed && $past(irq_enter)
    |-> (cur_set == clamp_set($past(irq_set), NUM_SETS)) && (saved_set == $past(cur_set)));
  // R7
  leave_chk: assert property (@(posedge clk) disable iff (rst)
    armed && $past(irq_return && !irq_enter)
    |-> (cur_set == $past(saved_set)) && $stable(saved_set));
  // R8
  range_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(cur_set) < NUM_SETS) && (int'(saved_set) < NUM_SETS));
  // R10
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    armed && $past(!irq_enter && !irq_return && !set_sel_en) |-> $stable(cur_set));
  // R10
  load_chk: assert property (@(posedge clk) disable iff (rst)
    armed && $past(set_sel_en && !irq_enter && !irq_return)
    |-> (cur_set == clamp_set($past(set_sel), NUM_SETS)) && $stable(saved_set));
endmodule

bind shadow_regfile srf_chk #(.NUM_SETS(NUM_SETS), .NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .set_sel_en(set_sel_en), .set_sel(set_sel),
  .irq_enter(irq_enter), .irq_set(irq_set), .irq_return(irq_return),
  .rd_a_addr(rd_a_addr), .rd_a_prev(rd_a_prev), .rd_b_addr(rd_b_addr),
  .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .rd_a_data(rd_a_data), .rd_b_data(rd_b_data),
  .cur_set(cur_set), .saved_set(saved_set)
);

// File: tb/tb_shadow_regfile.sv
module tb_shadow_regfile;
  localparam int NS = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        set_sel_en = 0, irq_enter = 0, irq_return = 0;
  logic [2:0]  set_sel = 0, irq_set = 0;
  logic [4:0]  rd_a_addr = 0, rd_b_addr = 0, wr_addr = 0;
  logic        rd_a_prev = 0, rd_b_prev = 0, wr_en = 0;
  logic [31:0] wr_data = 0;
  logic [31:0] rd_a_data, rd_b_data;
  logic [2:0]  cur_set, saved_set;

  always #4 clk = ~clk;

  shadow_regfile #(.NUM_SETS(NS)) dut (
    .clk(clk), .rst(rst), .set_sel_en(set_sel_en), .set_sel(set_sel),
    .irq_enter(irq_enter), .irq_set(irq_set), .irq_return(irq_return),
    .rd_a_addr(rd_a_addr), .rd_a_prev(rd_a_prev),
    .rd_b_addr(rd_b_addr), .rd_b_prev(rd_b_prev),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_a_data(rd_a_data), .rd_b_data(rd_b_data),
    .cur_set(cur_set), .saved_set(saved_set)
  );

  int n_tests = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  typedef struct { int due; logic [31:0] ea; logic [31:0] eb; string tag; } item_t;
  item_t sb[$];

  logic [31:0] mdl [8][32];
  logic [2:0]  m_cur = 0, m_saved = 0;

  function automatic void check(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endfunction

  function automatic logic [2:0] clampm(logic [2:0] s);
    return (int'(s) >= NS) ? 3'd0 : s;
  endfunction

  function automatic logic [31:0] expect_rd(logic [4:0] a, logic p, logic we,
                                             logic [4:0] wa, logic [31:0] wd);
    logic [2:0] s = p ? m_saved : m_cur;
    if (a == 0) return 32'd0;
    if (we && wa == a && s == m_cur) return wd;
    return mdl[s][a];
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pop expected read results when they fall due
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due == cyc) begin
      check({sb[0].tag, " port A"}, rd_a_data, sb[0].ea);
      check({sb[0].tag, " port B"}, rd_b_data, sb[0].eb);
      void'(sb.pop_front());
    end
  end

  // one cycle of stimulus; optionally scoreboards the reads
  task automatic op(logic we, logic [4:0] wa, logic [31:0] wd,
                    logic [4:0] aa, logic ap, logic [4:0] ba, logic bp,
                    logic ie, logic [2:0] is, logic ir, logic se, logic [2:0] ss,
                    bit do_rd, string tag);
    item_t it;
    @(negedge clk);
    wr_en = we; wr_addr = wa; wr_data = wd;
    rd_a_addr = aa; rd_a_prev = ap; rd_b_addr = ba; rd_b_prev = bp;
    irq_enter = ie; irq_set = is; irq_return = ir; set_sel_en = se; set_sel = ss;
    if (do_rd) begin
      it.due = cyc + 1;
      it.ea  = expect_rd(aa, ap, we, wa, wd);
      it.eb  = expect_rd(ba, bp, we, wa, wd);
      it.tag = tag;
      sb.push_back(it);
    end
    if (we && wa != 0) mdl[m_cur][wa] = wd;
    if (ie) begin m_saved = m_cur; m_cur = clampm(is); end
    else if (ir) m_cur = m_saved;
    else if (se) m_cur = clampm(ss);
  endtask

  task automatic idle();
    op(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "");
  endtask
  task automatic wr(logic [4:0] a, logic [31:0] d);
    op(1, a, d, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "");
  endtask
  task automatic rd(logic [4:0] a, logic ap, logic [4:0] b, logic bp, string tag);
    op(0, 0, 0, a, ap, b, bp, 0, 0, 0, 0, 0, 1, tag);
  endtask
  task automatic sets(string tag);
    idle();
    check({tag, " cur_set"}, 32'(cur_set), 32'(m_cur));
    check({tag, " saved_set"}, 32'(saved_set), 32'(m_saved));
  endtask

  initial begin
    for (int i = 0; i < NS; i++) mdl[i][0] = 32'd0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 0;
    // R1: reset state
    check("R1 cur_set", 32'(cur_set), 0);
    check("R1 saved_set", 32'(saved_set), 0);
    check("R1 rd_a_data", rd_a_data, 0);
    check("R1 rd_b_data", rd_b_data, 0);
    rd(0, 0, 0, 0, "R2 r0 after reset");
    // R3 / R4: basic writes and reads in copy 0
    wr(1, 32'hA000_0001); wr(2, 32'hA000_0002); wr(31, 32'hA000_001F);
    rd(1, 0, 2, 0, "R3 set0 r1/r2");
    rd(31, 0, 1, 0, "R3 set0 r31/r1");
    // R2: write to r0 ignored
    wr(0, 32'hDEAD_BEEF);
    rd(0, 0, 0, 0, "R2 r0 after write");
    // R5: same-cycle forwarding on both ports
    op(1, 5, 32'h5555_0005, 5, 0, 5, 0, 0, 0, 0, 0, 0, 1, "R5 forward");
    rd(5, 0, 2, 0, "R5 stored value");
    // R6: interrupt entry to copy 2
    op(0, 0, 0, 0, 0, 0, 0, 1, 3'd2, 0, 0, 0, 0, "");
    sets("R6 enter");
    // R4 / R9: new copy isolated, prev port reads interrupted copy
    wr(1, 32'hB000_0001);
    rd(1, 0, 1, 1, "R9 R4 active vs saved r1");
    rd(2, 1, 0, 0, "R9 R2 saved r2 and r0 in copy2");
    // R5: no forward to a port reading another copy
    op(1, 2, 32'hB000_0002, 2, 1, 2, 0, 0, 0, 0, 0, 0, 1, "R5 no forward across copies");
    // R7: return
    op(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, "");
    sets("R7 return");
    rd(1, 0, 2, 0, "R4 copy0 kept after return");
    // R10: direct load, R8: clamping on entry
    op(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 3'd1, 0, "");
    sets("R10 load 1");
    wr(3, 32'hC000_0003);
    op(0, 0, 0, 0, 0, 0, 0, 1, 3'd6, 0, 0, 0, 0, "");
    sets("R8 enter clamp");
    rd(3, 1, 1, 0, "R8 R9 saved copy1 r3, active copy0 r1");
    op(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 3'd3, 0, "");
    sets("R10 load 3");
    op(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 3'd7, 0, "");
    sets("R8 load clamp");
    // R10: priorities
    op(0, 0, 0, 0, 0, 0, 0, 1, 3'd2, 1, 1, 3'd3, 0, "");
    sets("R10 enter beats return and load");
    op(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 3'd3, 0, "");
    sets("R10 return beats load");
    rd(1, 0, 31, 0, "R3 copy0 after priority tests");
    repeat (3) idle();
    check("scoreboard drained", 32'(sb.size()), 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule